// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution unit of a CISC-style datapath. Each cycle it takes a source operand, a destination operand, an operation code, an operand size and the current five condition flags. One clock edge later it presents the new destination value and the new flag set. Only the low byte, word or long of the destination is replaced. The bits above the selected width come back unchanged, so the output can be written straight back into a 32-bit register.

The operations are:

- add and subtract, each with and without the extend flag as carry-in or borrow-in;
- quick add and quick subtract with a 3-bit literal from 1 to 8;
- AND, OR, XOR and NOT;
- clear;
- sign extension, byte to word and word to long.

The way the flags are updated depends on the operation class. Arithmetic copies carry into extend. Logic, clear and extension clear V and C and leave extend alone. A destination that is an address register keeps every flag as it was.

There is no state machine. The only storage is one result register and one flag register, both loaded on every clock edge, and an internal marker that records the first loaded edge after reset.

Top module: `cc_alu`

## Requirements
- R1: While rst_n is low, res_out and flags_out are zero. The reset is asynchronous and active low.
- R2: For op 0 (add) the result is dst_in + src_in, and for op 2 (subtract) it is dst_in - src_in, both at the selected width, with one cycle of latency. Flags are packed as bit4 X, bit3 N, bit2 Z, bit1 V, bit0 C. N is the result MSB, Z is set on a zero result, V flags signed overflow, C flags unsigned carry or borrow, and X equals C.
- R3: Op 1 (add with extend) adds flags_in bit4 as carry-in. Op 3 (subtract with extend) subtracts flags_in bit4 as borrow-in. Their flags follow R2.
- R4: Ops 11 (quick add) and 12 (quick subtract) use src_in[2:0] as the literal, with 0 meaning 8. src_in[31:3] is ignored. Their flags follow R2.
- R5: Ops 4 (AND), 5 (OR), 6 (XOR) and 7 (NOT of dst_in) give N from the result MSB and Z on a zero result. V and C are 0, and X keeps flags_in bit4.
- R6: Op 8 (clear) writes zero at the selected width and sets N=0, Z=1, V=0, C=0, keeping X.
- R7: Op 9 copies dst bit 7 into bits 15:8 and keeps bits 31:16. Op 10 copies dst bit 15 into bits 31:16. Both ignore size_in. Their flags follow R5, computed at 16 and 32 bits respectively.
- R8: size_in 0 selects byte, 1 selects word, and 2 or 3 select long. Destination bits above the width are passed through from dst_in.
- R9: When dst_addr is 1, flags_out equals flags_in. The result is still computed.
- R10: Op codes 13 to 15 return dst_in unchanged and flags_in unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_in | input | 4 | Operation code |
| size_in | input | 2 | Operand width select |
| src_in | input | 32 | Source operand or quick literal |
| dst_in | input | 32 | Destination operand |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| dst_addr | input | 1 | Destination is an address register |
| res_out | output | 32 | Merged destination value |
| flags_out | output | 5 | Updated flags {X,N,Z,V,C} |

## Verification
Every result and flag passes through exactly one register. A wrong width decode, carry-in or class decode therefore appears on res_out or flags_out one cycle after the offending input, and never later. Carries and overflows are placed at each of the three widths' sign boundaries, so a wrong width shows up as a wrong C or V. Upper-bit pass-through is checked with non-zero upper bits in dst_in. Extend-flag handling is checked by running the same operands with X at 0 and at 1.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1;
    localparam int IDX_W     = $clog2(NUM_SIZES);
    localparam int FLAG_W    = 5;

    localparam int FLG_X = 4;
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDX = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBX = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_CLR  = 4'd8,
        OP_EXTW = 4'd9,
        OP_EXTL = 4'd10,
        OP_ADDQ = 4'd11,
        OP_SUBQ = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_PASS  = 2'd2
    } flag_cls_e;

    function automatic logic [DATA_W-1:0] width_mask(input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < (8 << idx));
        end
        return m;
    endfunction
endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub
    import cc_alu_pkg::*;
#(
    parameter int W_DATA = DATA_W,
    parameter int N_SZ   = NUM_SIZES
) (
    input  logic                          sub_en,
    input  logic                          cin,
    input  logic [W_DATA-1:0]             src_op,
    input  logic [W_DATA-1:0]             dst_op,
    output logic [N_SZ-1:0][W_DATA-1:0]   res_all,
    output logic [N_SZ-1:0]               carry_all,
    output logic [N_SZ-1:0]               ovf_all
);
    for (genvar g = 0; g < N_SZ; g++) begin : g_width
        localparam int W = 8 << g;
        logic [W:0] ext_s;
        logic [W:0] ext_d;
        logic [W:0] ext_c;
        logic [W:0] sum;

        assign ext_s = {1'b0, src_op[W-1:0]};
        assign ext_d = {1'b0, dst_op[W-1:0]};
        assign ext_c = {{W{1'b0}}, cin};
        assign sum   = sub_en ? (ext_d - ext_s - ext_c) : (ext_d + ext_s + ext_c);

        if (W == W_DATA) begin : g_full
            assign res_all[g] = sum[W-1:0];
        end else begin : g_part
            assign res_all[g] = {{(W_DATA-W){1'b0}}, sum[W-1:0]};
        end

        assign carry_all[g] = sum[W];
        assign ovf_all[g]   = sub_en
            ? ((src_op[W-1] != dst_op[W-1]) && (sum[W-1] != dst_op[W-1]))
            : ((src_op[W-1] == dst_op[W-1]) && (sum[W-1] != dst_op[W-1]));
    end
endmodule

// File: rtl/cc_alu_unit.sv
module cc_alu_unit
    import cc_alu_pkg::*;
#(
    parameter int W_DATA = DATA_W
) (
    input  alu_op_e            op,
    input  logic [W_DATA-1:0]  src_op,
    input  logic [W_DATA-1:0]  dst_op,
    output logic [W_DATA-1:0]  unit_res
);
    localparam int HALF = W_DATA / 2;

    always_comb begin
        unique case (op)
            OP_AND:  unit_res = dst_op & src_op;
            OP_OR:   unit_res = dst_op | src_op;
            OP_XOR:  unit_res = dst_op ^ src_op;
            OP_NOT:  unit_res = ~dst_op;
            OP_EXTW: unit_res = {{(W_DATA-16){1'b0}}, {8{dst_op[7]}}, dst_op[7:0]};
            OP_EXTL: unit_res = {{HALF{dst_op[HALF-1]}}, dst_op[HALF-1:0]};
            default: unit_res = '0;
        endcase
    end
endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags
    import cc_alu_pkg::*;
#(
    parameter int W_DATA = DATA_W
) (
    input  flag_cls_e          cls,
    input  logic               to_addr,
    input  logic [IDX_W-1:0]   idx,
    input  logic [W_DATA-1:0]  raw_res,
    input  logic               carry,
    input  logic               ovf,
    input  logic [FLAG_W-1:0]  flags_cur,
    output logic [FLAG_W-1:0]  flags_new
);
    logic neg;
    logic zero;

    assign neg  = raw_res[(8 << idx) - 1];
    assign zero = ((raw_res & width_mask(idx)) == '0);

    always_comb begin
        flags_new = flags_cur;
        if (!to_addr) begin
            unique case (cls)
                CLS_ARITH: begin
                    flags_new[FLG_X] = carry;
                    flags_new[FLG_N] = neg;
                    flags_new[FLG_Z] = zero;
                    flags_new[FLG_V] = ovf;
                    flags_new[FLG_C] = carry;
                end
                CLS_LOGIC: begin
                    flags_new[FLG_N] = neg;
                    flags_new[FLG_Z] = zero;
                    flags_new[FLG_V] = 1'b0;
                    flags_new[FLG_C] = 1'b0;
                end
                default: flags_new = flags_cur;
            endcase
        end
    end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import cc_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op_in,
    input  logic [1:0]          size_in,
    input  logic [DATA_W-1:0]   src_in,
    input  logic [DATA_W-1:0]   dst_in,
    input  logic [FLAG_W-1:0]   flags_in,
    input  logic                dst_addr,
    output logic [DATA_W-1:0]   res_out,
    output logic [FLAG_W-1:0]   flags_out
);
    alu_op_e                       op_d;
    flag_cls_e                     cls_d;
    logic [IDX_W-1:0]              size_idx;
    logic [IDX_W-1:0]              idx_d;
    logic                          sub_d;
    logic                          cin_d;
    logic [DATA_W-1:0]             src_d;
    logic [NUM_SIZES-1:0][DATA_W-1:0] as_res;
    logic [NUM_SIZES-1:0]          as_carry;
    logic [NUM_SIZES-1:0]          as_ovf;
    logic [DATA_W-1:0]             unit_res;
    logic [DATA_W-1:0]             raw_d;
    logic [DATA_W-1:0]             mask_d;
    logic [DATA_W-1:0]             merged_d;
    logic [FLAG_W-1:0]             flags_d;
    logic                          armed;

    assign op_d = alu_op_e'(op_in);

    always_comb begin
        unique case (size_in)
            2'd0:    size_idx = IDX_W'(0);
            2'd1:    size_idx = IDX_W'(1);
            default: size_idx = IDX_W'(NUM_SIZES - 1);
        endcase
    end

    always_comb begin
        cls_d = CLS_PASS;
        idx_d = size_idx;
        sub_d = 1'b0;
        cin_d = 1'b0;
        src_d = src_in;
        unique case (op_d)
            OP_ADD:  cls_d = CLS_ARITH;
            OP_ADDX: begin cls_d = CLS_ARITH; cin_d = flags_in[FLG_X]; end
            OP_SUB:  begin cls_d = CLS_ARITH; sub_d = 1'b1; end
            OP_SUBX: begin cls_d = CLS_ARITH; sub_d = 1'b1; cin_d = flags_in[FLG_X]; end
            OP_ADDQ, OP_SUBQ: begin
                cls_d = CLS_ARITH;
                sub_d = (op_d == OP_SUBQ);
                src_d = (src_in[2:0] == 3'd0) ? DATA_W'(8) : DATA_W'(src_in[2:0]);
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_CLR: cls_d = CLS_LOGIC;
            OP_EXTW: begin cls_d = CLS_LOGIC; idx_d = IDX_W'(1); end
            OP_EXTL: begin cls_d = CLS_LOGIC; idx_d = IDX_W'(NUM_SIZES - 1); end
            default: cls_d = CLS_PASS;
        endcase
    end

    cc_alu_addsub u_addsub (
        .sub_en    (sub_d),
        .cin       (cin_d),
        .src_op    (src_d),
        .dst_op    (dst_in),
        .res_all   (as_res),
        .carry_all (as_carry),
        .ovf_all   (as_ovf)
    );

    cc_alu_unit u_unit (
        .op       (op_d),
        .src_op   (src_in),
        .dst_op   (dst_in),
        .unit_res (unit_res)
    );

    always_comb begin
        unique case (cls_d)
            CLS_ARITH: raw_d = as_res[idx_d];
            CLS_LOGIC: raw_d = unit_res;
            default:   raw_d = dst_in;
        endcase
        mask_d   = (cls_d == CLS_PASS) ? '0 : width_mask(idx_d);
        merged_d = (dst_in & ~mask_d) | (raw_d & mask_d);
    end

    cc_alu_flags u_flags (
        .cls       (cls_d),
        .to_addr   (dst_addr),
        .idx       (idx_d),
        .raw_res   (raw_d),
        .carry     (as_carry[idx_d]),
        .ovf       (as_ovf[idx_d]),
        .flags_cur (flags_in),
        .flags_new (flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_out   <= '0;
            flags_out <= '0;
            armed     <= 1'b0;
        end else begin
            res_out   <= merged_d;
            flags_out <= flags_d;
            armed     <= 1'b1;
        end
    end

    AST_ARITH_X_EQ_C: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cls_d == CLS_ARITH) && !$past(dst_addr) |-> flags_out[FLG_X] == flags_out[FLG_C]); // R2

    AST_LOGIC_VC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cls_d == CLS_LOGIC) && !$past(dst_addr)
        |-> flags_out[FLG_V:FLG_C] == 2'b00 && flags_out[FLG_X] == $past(flags_in[FLG_X])); // R5

    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_in == 4'd8) && !$past(dst_addr) |-> flags_out[FLG_N:FLG_C] == 4'b0100); // R6

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(size_in == 2'd0) && $past(op_in < 4'd9 || op_in > 4'd10)
        |-> res_out[DATA_W-1:8] == $past(dst_in[DATA_W-1:8])); // R8

    AST_ADDR_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(dst_addr) |-> flags_out == $past(flags_in)); // R9

    AST_UNDEF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_in > 4'd12) |-> res_out == $past(dst_in) && flags_out == $past(flags_in)); // R10
endmodule

// File: tb/cc_alu_tb.sv
module cc_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic [4:0]  fin;
        logic        adr;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] eres;
        logic [4:0]  efl;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{4'd0,  2'd0, 5'b00000, 1'b0, 32'h0000006B, 32'h1234565A, 32'h123456C5, 5'b01010, 4'd2}, // R2 byte overflow
        '{4'd0,  2'd1, 5'b00000, 1'b0, 32'h0000FFFF, 32'h00000001, 32'h00000000, 5'b10101, 4'd2}, // R2 word carry
        '{4'd0,  2'd2, 5'b00000, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 5'b01010, 4'd2}, // R2 long overflow
        '{4'd2,  2'd0, 5'b00000, 1'b0, 32'h00000020, 32'hAAAAAA10, 32'hAAAAAAF0, 5'b11001, 4'd2}, // R2 byte borrow
        '{4'd2,  2'd1, 5'b00000, 1'b0, 32'h00000001, 32'hFFFF8000, 32'hFFFF7FFF, 5'b00010, 4'd2}, // R2 word overflow
        '{4'd2,  2'd2, 5'b00000, 1'b0, 32'h00000005, 32'h00000005, 32'h00000000, 5'b00100, 4'd2}, // R2 zero
        '{4'd1,  2'd0, 5'b10000, 1'b0, 32'h00000001, 32'h000000FE, 32'h00000000, 5'b10101, 4'd3}, // R3 X=1
        '{4'd1,  2'd0, 5'b00000, 1'b0, 32'h00000001, 32'h000000FE, 32'h000000FF, 5'b01000, 4'd3}, // R3 X=0
        '{4'd3,  2'd1, 5'b10000, 1'b0, 32'h00000005, 32'h00000005, 32'h0000FFFF, 5'b11001, 4'd3}, // R3 borrow-in
        '{4'd3,  2'd2, 5'b00000, 1'b0, 32'h00000001, 32'h00000003, 32'h00000002, 5'b00000, 4'd3}, // R3
        '{4'd11, 2'd2, 5'b00000, 1'b0, 32'hFFFFFFF0, 32'h00000010, 32'h00000018, 5'b00000, 4'd4}, // R4 literal 0 -> 8
        '{4'd12, 2'd0, 5'b00000, 1'b0, 32'h00000003, 32'h00000002, 32'h000000FF, 5'b11001, 4'd4}, // R4
        '{4'd4,  2'd2, 5'b11111, 1'b0, 32'hF0F0F0F0, 32'h0F0FFFFF, 32'h0000F0F0, 5'b10000, 4'd5}, // R5 AND
        '{4'd5,  2'd0, 5'b00011, 1'b0, 32'h00000080, 32'h12345601, 32'h12345681, 5'b01000, 4'd5}, // R5 OR
        '{4'd6,  2'd1, 5'b10000, 1'b0, 32'h0000ABCD, 32'h5555ABCD, 32'h55550000, 5'b10100, 4'd5}, // R5 XOR
        '{4'd7,  2'd2, 5'b00000, 1'b0, 32'h12345678, 32'hFFFFFFFF, 32'h00000000, 5'b00100, 4'd5}, // R5 NOT
        '{4'd8,  2'd1, 5'b11011, 1'b0, 32'h00000000, 32'hDEADBEEF, 32'hDEAD0000, 5'b10100, 4'd6}, // R6
        '{4'd9,  2'd0, 5'b10011, 1'b0, 32'h00000000, 32'h000000C3, 32'h0000FFC3, 5'b11000, 4'd7}, // R7
        '{4'd10, 2'd0, 5'b00000, 1'b0, 32'h00000000, 32'h0000E1FC, 32'hFFFFE1FC, 5'b01000, 4'd7}, // R7
        '{4'd9,  2'd2, 5'b00000, 1'b0, 32'h00000000, 32'h12345678, 32'h12340078, 5'b00000, 4'd7}, // R7 keeps top
        '{4'd11, 2'd2, 5'b01101, 1'b1, 32'h00000001, 32'h0000FFFF, 32'h00010000, 5'b01101, 4'd9}, // R9
        '{4'd2,  2'd1, 5'b00000, 1'b1, 32'h00000001, 32'h00000000, 32'h0000FFFF, 5'b00000, 4'd9}, // R9
        '{4'd0,  2'd3, 5'b00000, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 5'b10101, 4'd8}, // R8 size 3
        '{4'd14, 2'd0, 5'b01010, 1'b0, 32'h00000001, 32'hCAFEF00D, 32'hCAFEF00D, 5'b01010, 4'd10}, // R10
        '{4'd0,  2'd0, 5'b00000, 1'b0, 32'h00000080, 32'h00000080, 32'h00000000, 5'b10111, 4'd8}  // R8 byte wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_in = '0;
    logic [1:0]  size_in = '0;
    logic [31:0] src_in = '0;
    logic [31:0] dst_in = '0;
    logic [4:0]  flags_in = '0;
    logic        dst_addr = 1'b0;
    logic [31:0] res_out;
    logic [4:0]  flags_out;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cc_alu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_in     (op_in),
        .size_in   (size_in),
        .src_in    (src_in),
        .dst_in    (dst_in),
        .flags_in  (flags_in),
        .dst_addr  (dst_addr),
        .res_out   (res_out),
        .flags_out (flags_out)
    );

    task automatic check(input string what, input int req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_in    = v.op;
        size_in  = v.sz;
        flags_in = v.fin;
        dst_addr = v.adr;
        src_in   = v.src;
        dst_in   = v.dst;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state with busy inputs
        drive(TBL[0]);
        repeat (3) @(negedge clk);
        check("reset result", 1, res_out, 32'h0);
        check("reset flags", 1, {27'b0, flags_out}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            check($sformatf("vector %0d result", i), int'(TBL[i].req), res_out, TBL[i].eres);
            check($sformatf("vector %0d flags", i), int'(TBL[i].req), {27'b0, flags_out}, {27'b0, TBL[i].efl});
        end

        // R4: upper literal bits ignored, literal 7 with noise above
        @(negedge clk);
        drive('{4'd11, 2'd0, 5'b00000, 1'b0, 32'hABCDEF07, 32'h00000001, 32'h0, 5'b0, 4'd4});
        @(negedge clk);
        check("quick add literal 7", 4, res_out, 32'h00000008);

        // R8: word add leaves top half of destination
        drive('{4'd0, 2'd1, 5'b00000, 1'b0, 32'hFFFF0001, 32'h87650001, 32'h0, 5'b0, 4'd8});
        @(negedge clk);
        check("word add top half", 8, res_out, 32'h87650002);

        // R1: asynchronous reset in mid-stream
        rst_n = 1'b0;
        #1;
        check("async reset result", 1, res_out, 32'h0);
        check("async reset flags", 1, {27'b0, flags_out}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule